// File: doc/BRIEF.md
# Packed Halfword Fractional Multiplier

This block multiplies signed 16-bit halfwords taken from two 32-bit source words. Each operation forms two products, called lane 1 and lane 0. A two-bit selector picks which halfwords feed each lane. An optional left shift by one turns the integer products into fractional (Q15 × Q15 → Q31) products. When that shift is on and both factors of a lane are the most negative halfword, the lane is clamped to the largest positive 32-bit value.

A form input chooses how the two lane products are returned:
- **Wide:** both 32-bit products side by side.
- **Summed:** one 64-bit sum of the two products, scaled up by 16 bits.
- **Rounded:** one 32-bit word holding the rounded upper halves of both products.

Overflow, advisory-overflow and sticky-advisory status bits are updated next to the result. An instruction pipeline feeds the block with already-decoded selector, shift and form fields. It gets back a registered result one cycle later, marked by a valid strobe.

Top module: `pk_frac_mul`

## Requirements
- R1: During and right after reset, `resValid`, `result`, `flagOvf`, `flagAdv` and `flagAdvSticky` are all zero.
- R2: `resValid` is high in exactly the cycle after each cycle in which `opValid` is high. `result` and the flags take their new values in that same cycle.
- R3: `laneSel` encoding, where hi = bits 31:16 and lo = bits 15:0:
  - 0: lane1 = A.hi×B.lo, lane0 = A.lo×B.lo
  - 1: lane1 = A.hi×B.lo, lane0 = A.lo×B.hi
  - 2: lane1 = A.hi×B.hi, lane0 = A.lo×B.lo
  - 3: lane1 = A.lo×B.hi, lane0 = A.hi×B.hi
- R4: Every halfword is multiplied as a signed two's-complement value. The 32-bit product is shifted left by one when `fracShift` is 1, and left as is when it is 0.
- R5: When `fracShift` is 1 and both factors of a lane equal 0x8000, that lane's value becomes 0x7FFFFFFF. Each lane is checked on its own, and with `fracShift` at 0 no clamping happens.
- R6: With `resForm` = 0 (wide), `result[63:32]` holds lane 1 and `result[31:0]` holds lane 0.
- R7: With `resForm` = 1 (summed), `result` is the signed 64-bit sum of the two lane values shifted left by 16. After such an operation `flagAdv` and `flagOvf` are 0 and `flagAdvSticky` is unchanged.
- R8: With `resForm` = 2 (rounded), each lane value gets 0x8000 added, except a clamped lane, which keeps 0x7FFFFFFF. Bits 31:16 of lane 1 go to `result[31:16]`, bits 31:16 of lane 0 go to `result[15:0]`, and `result[63:32]` is zero.
- R9: After a wide operation, `flagAdv` is 1 exactly when bit 31 differs from bit 30 in either 32-bit half of `result`.
- R10: After a rounded operation, `flagAdv` is 1 exactly when `result` bit 31 differs from bit 30, or bit 15 differs from bit 14.
- R11: Every operation in forms 0, 1 and 2 leaves `flagOvf` at 0.
- R12: `flagAdvSticky` takes the OR of its old value with each new `flagAdv`. Once set, it stays set until reset.
- R13: `resForm` = 3 is reserved. It returns a zero `result` and leaves all three flags unchanged.
- R14: In a cycle where `opValid` is low, the block holds `result` and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Operands and fields are sampled on this edge |
| srcA | input | 32 | First packed halfword source |
| srcB | input | 32 | Second packed halfword source |
| laneSel | input | 2 | Halfword pairing select (R3) |
| fracShift | input | 1 | Fractional left shift by one |
| resForm | input | 2 | Result form: 0 wide, 1 summed, 2 rounded, 3 reserved |
| resValid | output | 1 | Result is from the operation of the previous cycle |
| result | output | 64 | Registered result |
| flagOvf | output | 1 | Overflow status |
| flagAdv | output | 1 | Advisory overflow status |
| flagAdvSticky | output | 1 | Sticky advisory overflow |

## Verification
The four selectors are driven with four distinct halfwords, so that a swapped pairing shows up as a wrong product rather than an equal one. Negative factors check signed extension. Pairs of 0x8000 with the shift on and off separate the clamp from plain wrap. Cases where only one lane holds 0x8000 show that the lanes clamp independently. Values near the Q31 limits drive the advisory bits in the wide and rounded forms. The summed form must then clear them while the sticky bit keeps its value. Reserved-form operations and idle gaps confirm that state is held. Several thousand random operations, biased toward 0x8000, are compared every clock against a behavioural model.

// File: rtl/pkfm_pkg.sv
package pkfm_pkg;

  // Halfword pairing choice; the numeric values are the laneSel port encoding.
  typedef enum logic [1:0] {
    SEL_LL = 2'd0,
    SEL_LU = 2'd1,
    SEL_UL = 2'd2,
    SEL_UU = 2'd3
  } laneSel_e;

  // Result form; the numeric values are the resForm port encoding.
  typedef enum logic [1:0] {
    FORM_WIDE  = 2'd0,
    FORM_MPREC = 2'd1,
    FORM_ROUND = 2'd2,
    FORM_RSVD  = 2'd3
  } resForm_e;

  // Strobes sent from control to the datapath.
  typedef struct packed {
    logic     loadRes;
    logic     loadFlags;
    resForm_e form;
  } ctlStrobe_t;

endpackage

// File: rtl/pkfm_lane.sv
module pkfm_lane #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0]   opX,
  input  logic [HALF_W-1:0]   opY,
  input  logic                shiftOne,
  output logic [2*HALF_W-1:0] prodSh,
  output logic [HALF_W-1:0]   prodRndHi
);
  localparam int WORD_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] MIN_HALF = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] SAT_WORD = {1'b0, {(WORD_W-1){1'b1}}};

  logic signed [WORD_W-1:0] extX, extY, rawProd;
  logic [WORD_W-1:0] shifted;
  logic satHit;

  assign extX    = $signed({{HALF_W{opX[HALF_W-1]}}, opX});
  assign extY    = $signed({{HALF_W{opY[HALF_W-1]}}, opY});
  assign rawProd = extX * extY;
  assign shifted = shiftOne ? {rawProd[WORD_W-2:0], 1'b0} : rawProd;
  assign satHit  = shiftOne && (opX == MIN_HALF) && (opY == MIN_HALF);

  assign prodSh = satHit ? SAT_WORD : shifted;

  // Adding half an LSB of the upper half and keeping the upper half equals
  // incrementing the upper half by the bit just below it.
  assign prodRndHi = satHit ? SAT_WORD[WORD_W-1:HALF_W]
                            : shifted[WORD_W-1:HALF_W] + {{(HALF_W-1){1'b0}}, shifted[HALF_W-1]};
endmodule

// File: rtl/pkfm_ctrl.sv
module pkfm_ctrl
  import pkfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opValid,
  input  logic [1:0] formIn,
  output ctlStrobe_t strobe,
  output logic       resValid
);
  always_comb begin
    strobe.form      = resForm_e'(formIn);
    strobe.loadRes   = opValid;
    strobe.loadFlags = opValid && (resForm_e'(formIn) != FORM_RSVD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resValid <= 1'b0;
    else        resValid <= opValid;
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    opValid |=> resValid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> !resValid);
  assert_rsvd_no_flag_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (formIn == 2'd3) |-> !strobe.loadFlags);
endmodule

// File: rtl/pkfm_dpath.sv
module pkfm_dpath
  import pkfm_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctlStrobe_t          strobe,
  input  logic [2*HALF_W-1:0] srcA,
  input  logic [2*HALF_W-1:0] srcB,
  input  logic [1:0]          laneSel,
  input  logic                fracShift,
  output logic [4*HALF_W-1:0] result,
  output logic                flagOvf,
  output logic                flagAdv,
  output logic                flagAdvSticky
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int RES_W  = 4 * HALF_W;
  localparam int LANES  = 2;

  logic [HALF_W-1:0] hiA, loA, hiB, loB;
  logic [HALF_W-1:0] opX [LANES];
  logic [HALF_W-1:0] opY [LANES];
  logic [WORD_W-1:0] prodSh [LANES];
  logic [HALF_W-1:0] prodRndHi [LANES];

  assign hiA = srcA[WORD_W-1:HALF_W];
  assign loA = srcA[HALF_W-1:0];
  assign hiB = srcB[WORD_W-1:HALF_W];
  assign loB = srcB[HALF_W-1:0];

  // Halfword pairing per lane
  always_comb begin
    unique case (laneSel_e'(laneSel))
      SEL_LL: begin opX[1] = hiA; opY[1] = loB; opX[0] = loA; opY[0] = loB; end
      SEL_LU: begin opX[1] = hiA; opY[1] = loB; opX[0] = loA; opY[0] = hiB; end
      SEL_UL: begin opX[1] = hiA; opY[1] = hiB; opX[0] = loA; opY[0] = loB; end
      default: begin opX[1] = loA; opY[1] = hiB; opX[0] = hiA; opY[0] = hiB; end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pkfm_lane #(.HALF_W(HALF_W)) lane_i (
      .opX      (opX[g]),
      .opY      (opY[g]),
      .shiftOne (fracShift),
      .prodSh   (prodSh[g]),
      .prodRndHi(prodRndHi[g])
    );
  end

  // Result forms
  logic [RES_W-1:0]  wideRes, mpRes, rndRes, nextRes;
  logic [RES_W-1:0]  ext1, ext0;
  logic [WORD_W-1:0] packed16;
  logic avWide, avRnd, nextAv;

  assign wideRes  = {prodSh[1], prodSh[0]};
  assign ext1     = {{(RES_W-WORD_W){prodSh[1][WORD_W-1]}}, prodSh[1]};
  assign ext0     = {{(RES_W-WORD_W){prodSh[0][WORD_W-1]}}, prodSh[0]};
  assign mpRes    = (ext1 + ext0) << HALF_W;
  assign packed16 = {prodRndHi[1], prodRndHi[0]};
  assign rndRes   = {{(RES_W-WORD_W){1'b0}}, packed16};

  assign avWide = (prodSh[1][WORD_W-1] ^ prodSh[1][WORD_W-2]) |
                  (prodSh[0][WORD_W-1] ^ prodSh[0][WORD_W-2]);
  assign avRnd  = (packed16[WORD_W-1] ^ packed16[WORD_W-2]) |
                  (packed16[HALF_W-1] ^ packed16[HALF_W-2]);

  always_comb begin
    unique case (strobe.form)
      FORM_WIDE:  begin nextRes = wideRes; nextAv = avWide; end
      FORM_MPREC: begin nextRes = mpRes;   nextAv = 1'b0;   end
      FORM_ROUND: begin nextRes = rndRes;  nextAv = avRnd;  end
      default:    begin nextRes = '0;      nextAv = flagAdv; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result        <= '0;
      flagOvf       <= 1'b0;
      flagAdv       <= 1'b0;
      flagAdvSticky <= 1'b0;
    end else begin
      if (strobe.loadRes) result <= nextRes;
      if (strobe.loadFlags) begin
        flagOvf       <= 1'b0;
        flagAdv       <= nextAv;
        flagAdvSticky <= flagAdvSticky | nextAv;
      end
    end
  end

  assert_wide_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadRes && strobe.form == FORM_WIDE) |=>
      (flagAdv == ((result[RES_W-1] ^ result[RES_W-2]) | (result[WORD_W-1] ^ result[WORD_W-2]))));
  assert_round_adv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadRes && strobe.form == FORM_ROUND) |=>
      (flagAdv == ((result[WORD_W-1] ^ result[WORD_W-2]) | (result[HALF_W-1] ^ result[HALF_W-2]))));
  assert_round_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadRes && strobe.form == FORM_ROUND) |=> (result[RES_W-1:WORD_W] == '0));
  assert_mprec_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadRes && strobe.form == FORM_MPREC) |=> (!flagAdv && !flagOvf && $stable(flagAdvSticky)));
  assert_mprec_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadRes && strobe.form == FORM_MPREC) |=> (result[HALF_W-1:0] == '0));
  assert_ovf_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadFlags |=> !flagOvf);
  assert_sticky_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flagAdvSticky |=> flagAdvSticky);
  assert_sticky_covers_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flagAdv |-> flagAdvSticky);
  assert_rsvd_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadRes && strobe.form == FORM_RSVD) |=>
      (result == '0 && $stable(flagAdv) && $stable(flagAdvSticky) && $stable(flagOvf)));
  assert_idle_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadRes |=> ($stable(result) && $stable(flagAdv) && $stable(flagAdvSticky)));
endmodule

// File: rtl/pk_frac_mul.sv
module pk_frac_mul
  import pkfm_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                opValid,
  input  logic [2*HALF_W-1:0] srcA,
  input  logic [2*HALF_W-1:0] srcB,
  input  logic [1:0]          laneSel,
  input  logic                fracShift,
  input  logic [1:0]          resForm,
  output logic                resValid,
  output logic [4*HALF_W-1:0] result,
  output logic                flagOvf,
  output logic                flagAdv,
  output logic                flagAdvSticky
);
  ctlStrobe_t strobe;

  pkfm_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .opValid (opValid),
    .formIn  (resForm),
    .strobe  (strobe),
    .resValid(resValid)
  );

  pkfm_dpath #(.HALF_W(HALF_W)) dpath_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .srcA         (srcA),
    .srcB         (srcB),
    .laneSel      (laneSel),
    .fracShift    (fracShift),
    .result       (result),
    .flagOvf      (flagOvf),
    .flagAdv      (flagAdv),
    .flagAdvSticky(flagAdvSticky)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!resValid && result == '0 && !flagAdv && !flagAdvSticky && !flagOvf));
endmodule

// File: tb/pk_frac_mul_tb_top.sv
`timescale 1ns/1ps
module pk_frac_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [1:0]  laneSel = '0;
  logic        fracShift = 1'b0;
  logic [1:0]  resForm = '0;
  logic        resValid;
  logic [63:0] result;
  logic        flagOvf, flagAdv, flagAdvSticky;

  int total = 0;
  int bad = 0;
  bit running = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pk_frac_mul dut_i (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .srcA(srcA), .srcB(srcB),
    .laneSel(laneSel), .fracShift(fracShift), .resForm(resForm),
    .resValid(resValid), .result(result), .flagOvf(flagOvf),
    .flagAdv(flagAdv), .flagAdvSticky(flagAdvSticky)
  );

  // Behavioural reference state
  logic [63:0] expRes = '0;
  logic expValid = 0, expOvf = 0, expAdv = 0, expSticky = 0;
  string resTag = "R1", advTag = "R1";

  function automatic longint laneVal(logic [15:0] x, logic [15:0] y, bit n);
    longint p;
    p = longint'($signed(x)) * longint'($signed(y));
    if (n) p = p * 2;
    if (n && x == 16'h8000 && y == 16'h8000) p = 64'sh7FFFFFFF;
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      expRes = '0; expValid = 0; expOvf = 0; expAdv = 0; expSticky = 0;
    end else begin
      expValid = opValid;
      if (!opValid) begin
        resTag = "R14"; advTag = "R14";
      end else begin
        logic [15:0] ah, al, bh, bl, x1, y1, x0, y0, r1, r0;
        longint p1, p0, s;
        ah = srcA[31:16]; al = srcA[15:0]; bh = srcB[31:16]; bl = srcB[15:0];
        case (laneSel)   // R3 pairing table
          2'd0: begin x1 = ah; y1 = bl; x0 = al; y0 = bl; end
          2'd1: begin x1 = ah; y1 = bl; x0 = al; y0 = bh; end
          2'd2: begin x1 = ah; y1 = bh; x0 = al; y0 = bl; end
          default: begin x1 = al; y1 = bh; x0 = ah; y0 = bh; end
        endcase
        p1 = laneVal(x1, y1, fracShift);
        p0 = laneVal(x0, y0, fracShift);
        case (resForm)
          2'd0: begin
            expRes = {p1[31:0], p0[31:0]};
            expAdv = (expRes[63] != expRes[62]) || (expRes[31] != expRes[30]);
            expOvf = 0; expSticky = expSticky | expAdv;
            resTag = "R6 R3 R4 R5"; advTag = "R9";
          end
          2'd1: begin
            s = (p1 + p0) * 65536;
            expRes = s;
            expAdv = 0; expOvf = 0;
            resTag = "R7 R3 R4 R5"; advTag = "R7";
          end
          2'd2: begin
            r1 = (p1 == 64'sh7FFFFFFF && fracShift && x1 == 16'h8000) ? 16'h7FFF : 16'((p1 + 32768) >>> 16);
            r0 = (p0 == 64'sh7FFFFFFF && fracShift && x0 == 16'h8000) ? 16'h7FFF : 16'((p0 + 32768) >>> 16);
            expRes = {32'h0, r1, r0};
            expAdv = (expRes[31] != expRes[30]) || (expRes[15] != expRes[14]);
            expOvf = 0; expSticky = expSticky | expAdv;
            resTag = "R8 R3 R5"; advTag = "R10";
          end
          default: begin
            expRes = '0;
            resTag = "R13"; advTag = "R13";
          end
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R2", 64'(resValid), 64'(expValid));
      chk(resTag, result, expRes);
      chk(advTag, 64'(flagAdv), 64'(expAdv));
      chk("R11", 64'(flagOvf), 64'(expOvf));
      chk("R12", 64'(flagAdvSticky), 64'(expSticky));
    end
  end

  task automatic op(logic [31:0] a, logic [31:0] b, logic [1:0] sel, bit n, logic [1:0] form);
    @(negedge clk);
    srcA = a; srcB = b; laneSel = sel; fracShift = n; resForm = form; opValid = 1'b1;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      opValid = 1'b0; srcA = $urandom; srcB = $urandom;
    end
  endtask

  function automatic logic [15:0] pickHalf();
    int r;
    r = $urandom_range(0, 7);
    if (r == 0) return 16'h8000;
    if (r == 1) return 16'h7FFF;
    if (r == 2) return 16'hFFFF;
    return 16'($urandom);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1", {resValid, flagOvf, flagAdv, flagAdvSticky}, 64'h0);
    chk("R1", result, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {resValid, flagOvf, flagAdv, flagAdvSticky}, 64'h0);
    chk("R1", result, 64'h0);
    running = 1;

    // R3 R4: distinct halfwords on every pairing, wide and summed
    for (int s = 0; s < 4; s++) begin
      op(32'h0003_FFFB, 32'h0007_000B, 2'(s), 0, 2'd0);
      op(32'h1234_8765, 32'hFEDC_0102, 2'(s), 1, 2'd0);
      op(32'h0003_FFFB, 32'h0007_000B, 2'(s), 1, 2'd1);
      op(32'h4000_C000, 32'h2000_E000, 2'(s), 1, 2'd2);
    end
    // R5: clamp both lanes, one lane, and no clamp without shift
    op(32'h8000_8000, 32'h8000_8000, 2'd2, 1, 2'd0);
    op(32'h8000_1234, 32'h8000_8000, 2'd2, 1, 2'd0);
    op(32'h8000_8000, 32'h8000_8000, 2'd2, 0, 2'd0); // R9: bit30 set
    op(32'h8000_8000, 32'h8000_8000, 2'd0, 1, 2'd1);
    op(32'h8000_8000, 32'h8000_8000, 2'd3, 1, 2'd2);
    // R10: rounding carry reaching bit 15
    op(32'h7FFF_7FFF, 32'h7FFF_7FFF, 2'd2, 1, 2'd2);
    op(32'h4000_4000, 32'h4000_4000, 2'd2, 0, 2'd2);
    // R13: reserved form with sticky set
    op(32'h1111_2222, 32'h3333_4444, 2'd1, 1, 2'd3);
    idle(3); // R14
    op(32'h0001_0001, 32'h0001_0001, 2'd0, 0, 2'd1);
    op(32'hDEAD_BEEF, 32'h1234_5678, 2'd3, 0, 2'd3);
    idle(2);

    for (int i = 0; i < 4000; i++) begin
      op({pickHalf(), pickHalf()}, {pickHalf(), pickHalf()}, 2'($urandom), 1'($urandom),
         2'($urandom_range(0, 9) == 0 ? 3 : $urandom_range(0, 2)));
      if ($urandom_range(0, 7) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(3);
    running = 0;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule